// File: doc/BRIEF.md
# Mode Register Command Issuer

This block lets software ask for a single mode register write or read toward a chosen DRAM rank. Software programs two control words through a plain word-addressed register port. The first word holds the target rank and the command type, and the second holds the mode register address and the write byte. Software then sets a start bit. The block raises a busy flag and offers the request to a DRAM command scheduler with a valid/ready handshake. It then waits for the scheduler to report completion. Control writes made while the block is busy have no effect. Software therefore polls the busy flag before it programs the next request.

For a read, the byte returned by the scheduler goes into a read-data register, and a sticky valid flag is set in a read-status register. Software arms that status register before the read and clears the flag afterwards, each time by writing a specific code. The captured byte stays in place until the next read completes.

Register map (word offsets on `csr_addr`): 0 status, 1 control 0, 2 control 1, 3 read status, 4 read data. Any other offset reads as zero.

Top module: `mrc_issuer`

## Requirements
- R1: After reset, the status, control 0, control 1, read-status and read-data registers all read zero, and `cmd_valid` is low.
- R2: Status bit 0 is busy. It reads 1 from the cycle after a write to control 0 with bit 31 set, made while idle. It returns to 0 the cycle after `resp_valid` completes the request.
- R3: In control 0, bit 0 is the command type (1 = read, 0 = write) and bits [4 +: RANK_W] are the rank. A readback returns these fields, and bit 31 always reads 0.
- R4: In control 1, bits 15:8 are the mode register address and bits 7:0 are the write data. Both read back as written.
- R5: `cmd_valid` is high from the cycle after launch until the cycle after `cmd_ready` is seen. While it waits, `cmd_is_read`, `cmd_rank`, `cmd_mr_addr` and `cmd_mr_data` stay stable and equal the programmed fields.
- R6: Writes to control 0 or control 1 made while busy are ignored. The readback and the command fields are unchanged, and a start bit in such a write launches nothing.
- R7: When a read completes, read-status bit 3 is set and read-data bits 7:0 are loaded from `resp_data`. A completed write changes neither register.
- R8: Writing 0x4 to read status clears bit 3 and bit 0. Writing 0x1 sets bit 0 (armed) and clears bit 3. Any other value is ignored. A read completion clears bit 0.
- R9: When a read completes in the same cycle as a clearing write to read status, the completion wins and bit 3 ends up set.
- R10: Read data keeps its value until the next read completes. Clear and arm writes do not change it.
- R11: A `resp_valid` pulse counts only after the request has been accepted. While the block is idle or still waiting for `cmd_ready`, the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wen | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word offset for write and read |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` (combinational) |
| cmd_valid | output | 1 | Request offered to the scheduler |
| cmd_ready | input | 1 | Scheduler accepts the request |
| cmd_is_read | output | 1 | 1 = mode register read, 0 = write |
| cmd_rank | output | RANK_W | Target rank |
| cmd_mr_addr | output | 8 | Mode register address |
| cmd_mr_data | output | 8 | Mode register write data |
| resp_valid | input | 1 | Scheduler reports completion |
| resp_data | input | 8 | Byte returned on a read completion |

## Verification
Two events can fall in the same cycle: a read completion from the scheduler, and a software write of the clear code to read status. The bench can drive `resp_valid` and that register write on the same clock edge, either through a directed case or when the random loop chooses to. It then expects the valid flag set and the new byte captured. A clear that lands with a write completion is expected to take full effect. A second overlap is also exercised: control writes issued while the request is pending. These are judged by the readback and by the command outputs, which must not change.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    localparam int CSR_AW = 3;
    localparam int CSR_DW = 32;

    localparam logic [CSR_AW-1:0] OFS_STATUS = 3'd0;
    localparam logic [CSR_AW-1:0] OFS_CTRL0  = 3'd1;
    localparam logic [CSR_AW-1:0] OFS_CTRL1  = 3'd2;
    localparam logic [CSR_AW-1:0] OFS_RDSTAT = 3'd3;
    localparam logic [CSR_AW-1:0] OFS_RDDATA = 3'd4;

    localparam int GO_BIT    = 31;
    localparam int KIND_BIT  = 0;
    localparam int RANK_LSB  = 4;
    localparam int VALID_BIT = 3;
    localparam int ARM_BIT   = 0;

    localparam logic [CSR_DW-1:0] CODE_CLEAR = 32'h4;
    localparam logic [CSR_DW-1:0] CODE_ARM   = 32'h1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_WAIT  = 2'd2
    } issue_state_e;

    typedef struct packed {
        logic       is_read;
        logic [7:0] mr_addr;
        logic [7:0] mr_data;
    } mr_body_t;

    function automatic logic [CSR_DW-1:0] pack_body(input mr_body_t b);
        return {16'h0, b.mr_addr, b.mr_data};
    endfunction

    function automatic logic [CSR_DW-1:0] pack_rdstat(input logic valid, input logic armed);
        logic [CSR_DW-1:0] w;
        w = '0;
        w[VALID_BIT] = valid;
        w[ARM_BIT]   = armed;
        return w;
    endfunction

endpackage

// File: rtl/mrc_ctrl_regs.sv
module mrc_ctrl_regs
    import mrc_pkg::*;
#(
    parameter int RANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [CSR_AW-1:0] waddr,
    input  logic              w_go,
    input  logic              w_kind,
    input  logic [RANK_W-1:0] w_rank,
    input  logic [15:0]       w_low,
    input  logic              busy,
    output mr_body_t          body,
    output logic [RANK_W-1:0] rank,
    output logic              launch
);

    logic wr_c0, wr_c1;

    assign wr_c0  = wen && (waddr == OFS_CTRL0) && !busy;
    assign wr_c1  = wen && (waddr == OFS_CTRL1) && !busy;
    assign launch = wr_c0 && w_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            body <= '0;
            rank <= '0;
        end else begin
            if (wr_c0) begin
                body.is_read <= w_kind;
                rank         <= w_rank;
            end
            if (wr_c1) begin
                body.mr_addr <= w_low[15:8];
                body.mr_data <= w_low[7:0];
            end
        end
    end

    // R6
    hold_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(body) && $stable(rank)));

endmodule

// File: rtl/mrc_issue_fsm.sv
module mrc_issue_fsm
    import mrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic is_read,
    input  logic cmd_ready,
    input  logic resp_valid,
    output logic cmd_valid,
    output logic busy,
    output logic rd_done
);

    issue_state_e state, state_nx;
    logic         finish;

    assign finish    = (state == ST_WAIT) && resp_valid;
    assign cmd_valid = (state == ST_OFFER);
    assign busy      = (state != ST_IDLE);
    assign rd_done   = finish && is_read;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (launch)    state_nx = ST_OFFER;
            ST_OFFER: if (cmd_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (resp_valid) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // R2
    launch_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> (busy && cmd_valid));

    // R2
    finish_drops_busy_chk: assert property (@(posedge clk) disable iff (rst)
        finish |=> !busy);

    // R5
    offer_held_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> cmd_valid);

    // R11
    early_resp_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready && resp_valid) |=> busy);

endmodule

// File: rtl/mrc_read_capture.sv
module mrc_read_capture
    import mrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_done,
    input  logic [7:0]        resp_data,
    input  logic              stat_wen,
    input  logic [CSR_DW-1:0] stat_wdata,
    output logic              rd_valid,
    output logic              armed,
    output logic [7:0]        rd_byte
);

    logic do_clear, do_arm;

    assign do_clear = stat_wen && (stat_wdata == CODE_CLEAR);
    assign do_arm   = stat_wen && (stat_wdata == CODE_ARM);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            armed    <= 1'b0;
            rd_byte  <= '0;
        end else if (rd_done) begin
            rd_valid <= 1'b1;
            armed    <= 1'b0;
            rd_byte  <= resp_data;
        end else if (do_clear) begin
            rd_valid <= 1'b0;
            armed    <= 1'b0;
        end else if (do_arm) begin
            rd_valid <= 1'b0;
            armed    <= 1'b1;
        end
    end

    // R9
    done_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> rd_valid);

    // R10
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_done |=> $stable(rd_byte));

endmodule

// File: rtl/mrc_issuer.sv
module mrc_issuer
    import mrc_pkg::*;
#(
    parameter int RANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wen,
    input  logic [2:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_is_read,
    output logic [RANK_W-1:0] cmd_rank,
    output logic [7:0]        cmd_mr_addr,
    output logic [7:0]        cmd_mr_data,
    input  logic              resp_valid,
    input  logic [7:0]        resp_data
);

    localparam int RANK_MSB = RANK_LSB + RANK_W - 1;

    mr_body_t          body;
    logic [RANK_W-1:0] rank;
    logic              launch, busy, rd_done;
    logic              rd_valid, armed;
    logic [7:0]        rd_byte;
    logic              stat_wen;

    assign stat_wen = csr_wen && (csr_addr == OFS_RDSTAT);

    mrc_ctrl_regs #(.RANK_W(RANK_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wen    (csr_wen),
        .waddr  (csr_addr),
        .w_go   (csr_wdata[GO_BIT]),
        .w_kind (csr_wdata[KIND_BIT]),
        .w_rank (csr_wdata[RANK_MSB:RANK_LSB]),
        .w_low  (csr_wdata[15:0]),
        .busy   (busy),
        .body   (body),
        .rank   (rank),
        .launch (launch)
    );

    mrc_issue_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .is_read    (body.is_read),
        .cmd_ready  (cmd_ready),
        .resp_valid (resp_valid),
        .cmd_valid  (cmd_valid),
        .busy       (busy),
        .rd_done    (rd_done)
    );

    mrc_read_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .rd_done    (rd_done),
        .resp_data  (resp_data),
        .stat_wen   (stat_wen),
        .stat_wdata (csr_wdata),
        .rd_valid   (rd_valid),
        .armed      (armed),
        .rd_byte    (rd_byte)
    );

    assign cmd_is_read = body.is_read;
    assign cmd_rank    = rank;
    assign cmd_mr_addr = body.mr_addr;
    assign cmd_mr_data = body.mr_data;

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            OFS_STATUS: csr_rdata[0] = busy;
            OFS_CTRL0: begin
                csr_rdata[KIND_BIT]          = body.is_read;
                csr_rdata[RANK_MSB:RANK_LSB] = rank;
            end
            OFS_CTRL1:  csr_rdata = pack_body(body);
            OFS_RDSTAT: csr_rdata = pack_rdstat(rd_valid, armed);
            OFS_RDDATA: csr_rdata[7:0] = rd_byte;
            default:    csr_rdata = '0;
        endcase
    end

    // R5
    fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> ($stable(cmd_is_read) && $stable(cmd_rank)
            && $stable(cmd_mr_addr) && $stable(cmd_mr_data)));

    // R7
    write_done_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd_is_read && !stat_wen) |=> $stable(rd_valid));

endmodule

// File: tb/mrc_issuer_tb.sv
module mrc_issuer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RANK_W = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              csr_wen = 1'b0;
    logic [2:0]        csr_addr = '0;
    logic [31:0]       csr_wdata = '0;
    logic [31:0]       csr_rdata;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic              cmd_is_read;
    logic [RANK_W-1:0] cmd_rank;
    logic [7:0]        cmd_mr_addr;
    logic [7:0]        cmd_mr_data;
    logic              resp_valid = 1'b0;
    logic [7:0]        resp_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of software-visible state
    logic              m_kind;
    logic [RANK_W-1:0] m_rank;
    logic [7:0]        m_addr, m_data, m_byte;
    logic              m_valid, m_armed;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrc_issuer #(.RANK_W(RANK_W)) u_dut (
        .clk(clk), .rst(rst), .csr_wen(csr_wen), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_is_read(cmd_is_read), .cmd_rank(cmd_rank),
        .cmd_mr_addr(cmd_mr_addr), .cmd_mr_data(cmd_mr_data),
        .resp_valid(resp_valid), .resp_data(resp_data)
    );

    function automatic logic [31:0] exp_c0(logic kind, logic [RANK_W-1:0] rk);
        return (32'(rk) << 4) | 32'(kind);
    endfunction

    function automatic logic [31:0] exp_c1(logic [7:0] a, logic [7:0] d);
        return {16'h0, a, d};
    endfunction

    function automatic logic [31:0] exp_rs(logic v, logic ar);
        return {28'h0, v, 2'b00, ar};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wen = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wen = 1'b0; csr_wdata = '0;
    endtask

    task automatic chk_regs(input string tag, input logic busy_exp);
        logic [31:0] v;
        rd(3'd0, v); chk({tag, " R2 busy"}, v, {31'h0, busy_exp});
        rd(3'd1, v); chk({tag, " R3 ctrl0"}, v, exp_c0(m_kind, m_rank));
        rd(3'd2, v); chk({tag, " R4 ctrl1"}, v, exp_c1(m_addr, m_data));
        rd(3'd3, v); chk({tag, " R8 rdstat"}, v, exp_rs(m_valid, m_armed));
        rd(3'd4, v); chk({tag, " R10 rddata"}, v, {24'h0, m_byte});
    endtask

    task automatic chk_cmd(input string tag, input logic vld);
        chk({tag, " R5 valid"}, {31'h0, cmd_valid}, {31'h0, vld});
        chk({tag, " R5 fields"}, {7'h0, cmd_is_read, 6'(cmd_rank), cmd_mr_addr, cmd_mr_data},
            {7'h0, m_kind, 6'(m_rank), m_addr, m_data});
    endtask

    task automatic stat_write(input logic [31:0] v);
        wr(3'd3, v);
        if (v == 32'h4) begin m_valid = 0; m_armed = 0; end
        else if (v == 32'h1) begin m_valid = 0; m_armed = 1; end
    endtask

    task automatic txn(input logic kind, input logic [RANK_W-1:0] rk, input logic [7:0] a,
                       input logic [7:0] d, input logic [7:0] rdat, input int dly,
                       input bit clash, input bit early);
        wr(3'd2, exp_c1(a, d));
        wr(3'd1, 32'h8000_0000 | exp_c0(kind, rk));
        m_kind = kind; m_rank = rk; m_addr = a; m_data = d;
        chk_regs("launch", 1'b1);
        chk_cmd("launch", 1'b1);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk_cmd("wait", 1'b1);
        end
        // R6: programming attempts while busy
        wr(3'd1, 32'h8000_0000 | 32'($urandom) | ~exp_c0(kind, rk));
        wr(3'd2, ~exp_c1(a, d));
        chk_regs("busy-write R6", 1'b1);
        chk_cmd("busy-write R6", 1'b1);
        if (early) begin
            // R11: response before acceptance
            @(negedge clk); resp_valid = 1; resp_data = ~rdat;
            @(negedge clk); resp_valid = 0;
            chk_regs("early R11", 1'b1);
            chk_cmd("early R11", 1'b1);
        end
        @(negedge clk); cmd_ready = 1;
        @(negedge clk); cmd_ready = 0;
        chk_cmd("accepted", 1'b0);
        chk_regs("accepted", 1'b1);
        @(negedge clk);
        resp_valid = 1; resp_data = rdat;
        if (clash) begin csr_wen = 1; csr_addr = 3'd3; csr_wdata = 32'h4; end
        @(negedge clk);
        resp_valid = 0; csr_wen = 0; csr_wdata = '0;
        if (kind) begin
            m_valid = 1; m_armed = 0; m_byte = rdat;  // R7, R9
        end else if (clash) begin
            m_valid = 0; m_armed = 0;
        end
        chk_regs(clash ? "complete R9" : "complete R7", 1'b0);
        chk_cmd("complete", 1'b0);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_1234));
        m_kind = 0; m_rank = 0; m_addr = 0; m_data = 0; m_byte = 0; m_valid = 0; m_armed = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk_regs("reset R1", 1'b0);
        chk_cmd("reset R1", 1'b0);
        rd(3'd6, v); chk("R1 unmapped", v, 32'h0);

        // R11: response while idle
        @(negedge clk); resp_valid = 1; resp_data = 8'hEE;
        @(negedge clk); resp_valid = 0;
        chk_regs("idle resp R11", 1'b0);

        // R3/R4: programming without start
        wr(3'd1, 32'h7FFF_FFFF);
        m_kind = 1; m_rank = '1;
        wr(3'd2, 32'hFFFF_A55A);
        m_addr = 8'hA5; m_data = 8'h5A;
        chk_regs("program R3 R4", 1'b0);

        // directed: arm, read, clash
        stat_write(32'h1);
        chk_regs("arm R8", 1'b0);
        txn(1, 2'd3, 8'h0E, 8'h00, 8'hC3, 2, 0, 1);
        stat_write(32'h7);   // R8 ignored code
        chk_regs("junk R8", 1'b0);
        stat_write(32'h4);
        chk_regs("clear R8 R10", 1'b0);
        txn(1, 2'd1, 8'h05, 8'h00, 8'h3C, 0, 1, 0);  // R9 clash
        txn(0, 2'd2, 8'h0D, 8'h77, 8'h99, 1, 0, 0);  // R7 write leaves byte
        txn(0, 2'd0, 8'h01, 8'h11, 8'h22, 0, 1, 0);  // clear with write completion

        // random
        for (int it = 0; it < 40; it++) begin
            int op = $urandom % 4;
            if (op == 0) stat_write(32'h1);
            else if (op == 1) stat_write(32'h4);
            else if (op == 2) stat_write($urandom % 16);
            txn($urandom % 2, RANK_W'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                $urandom % 4, ($urandom % 4) == 0, ($urandom % 4) == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule